// File: doc/BRIEF.md
# Flash Command Sequencer

This block puts a command-driven front end on a small NOR-style word array with a 16-bit data bus. Software talks to it through single-cycle bus writes. The low byte of each write is read as a command code, and later writes of a multi-cycle sequence are read as data. Reads are combinational from the address. The read mode decides what a read returns: array contents, identifier words, query words or the status register. The read mode is selected by command.

A small internal write engine runs three kinds of operation: single-word program, buffered program of up to `BUF_DEPTH` words, and block erase. Each one keeps the engine busy for `BUSY_CYC` cycles. Programming can only clear bits, and erase sets every word of one block back to all ones. A running operation can be suspended and then resumed. A status byte reports whether the engine is ready, which kind of operation is suspended, and two sticky error flags that software clears with a command.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, every array word reads 0xFFFF, the read mode is array, and the status register reads 0x0080. The status word has 0 in bits 15:8. Its low byte is: bit 7 ready, bit 6 erase suspended, bit 5 sequence/erase error, bit 4 program error, bit 2 program suspended, and bits 3, 1 and 0 always 0.
- R2: The command byte is wdata[7:0]. 0xFF selects array reads. 0x70 selects status reads. 0x90 selects identifier reads, which return 0x00A5 at address 0, 0x5A17 at address 1 and 0 elsewhere. 0x98 selects query reads, which return 0x0051, 0x0052 and 0x0059 at addresses 0x10, 0x11 and 0x12 and 0 elsewhere.
- R3: Word program is the code 0x40 followed by a write that carries the target address and the data. The word becomes its old value ANDed with the data. Status bit 7 reads 0 for exactly `BUSY_CYC` cycles, counted from the data write.
- R4: Buffered program takes these writes in order: 0xE8 at an address in the target block, a count N (1..`BUF_DEPTH`), N address/data writes inside that block, then 0xD0. Each listed word is ANDed with its data, and all other words are left unchanged.
- R5: During a buffer fill, a write to an address in another block ends the sequence at once. Nothing is programmed, status bit 4 is set, and the next write is decoded as a new command.
- R6: A buffer count of 0, or a count larger than `BUF_DEPTH`, sets status bits 5 and 4 and changes no array word.
- R7: Block erase is 0x20 followed by 0xD0 at an address in the block. Every word of that block becomes 0xFFFF, and other blocks are unchanged. Blocks are 2^`BLK_W` words, aligned.
- R8: Any code other than 0xD0 in the confirm write after 0x20, or at the end of a buffer fill, sets status bits 5 and 4 and changes no array word.
- R9: Status bits 5 and 4 stay set through later operations and mode changes. The 0x50 command clears both and changes no other status bit.
- R10: Every program or erase setup switches reads to status mode. While the engine is busy, a read in array mode returns the status word.
- R11: 0xB0 while busy suspends the operation. Bit 7 reads 1, and bit 6 (erase) or bit 2 (program) reads 1. The operation stays stalled, and array reads are allowed. 0xD0 resumes it: bit 7 returns to 0, the suspend bit clears, and the operation then finishes.
- R12: A 0xB0 write taken on the same clock edge on which the operation finishes has no effect. The operation completes and no suspend bit is set.
- R13: When no sequence is in progress, a code outside the command set changes neither the read mode nor the array.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| we | input | 1 | Bus write strobe, one write per cycle |
| addr | input | ADDR_W | Word address for reads and writes |
| wdata | input | 16 | Write data; low byte carries command codes |
| rdata | output | 16 | Read data for `addr` in the current read mode |

## Verification
A suspend write can land on the very edge where the write engine finishes its countdown and commits. The suspend request and the completion then compete for the same state update. The bench starts a word program and times the 0xB0 write to be captured exactly `BUSY_CYC` edges after the data write. It then expects a ready status with no suspend bit and the programmed word in the array. A control case places the 0xB0 one edge earlier and expects the program-suspended status, followed by a correct resume.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

    typedef enum logic [1:0] {
        RM_ARRAY,
        RM_IDENT,
        RM_STATUS,
        RM_QUERY
    } rmode_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WP_DATA,
        S_ER_CONF,
        S_BP_CNT,
        S_BP_LOAD,
        S_BP_CONF,
        S_BUSY,
        S_SUSP
    } st_e;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_WORD,
        OP_BUF,
        OP_ERASE
    } op_e;

    localparam logic [7:0] CMD_RD_ARR  = 8'hFF;
    localparam logic [7:0] CMD_RD_ID   = 8'h90;
    localparam logic [7:0] CMD_RD_QRY  = 8'h98;
    localparam logic [7:0] CMD_RD_STAT = 8'h70;
    localparam logic [7:0] CMD_CLR     = 8'h50;
    localparam logic [7:0] CMD_WORD    = 8'h40;
    localparam logic [7:0] CMD_BUF     = 8'hE8;
    localparam logic [7:0] CMD_ERASE   = 8'h20;
    localparam logic [7:0] CMD_CONF    = 8'hD0;
    localparam logic [7:0] CMD_SUSP    = 8'hB0;

    function automatic rmode_e mode_after(input logic [7:0] c, input rmode_e cur);
        case (c)
            CMD_RD_ARR:  return RM_ARRAY;
            CMD_RD_ID:   return RM_IDENT;
            CMD_RD_QRY:  return RM_QUERY;
            CMD_RD_STAT: return RM_STATUS;
            default:     return cur;
        endcase
    endfunction

endpackage

// File: rtl/fcs_array.sv
module fcs_array #(
    parameter int ADDR_W = 8,
    parameter int BLK_W  = 4,
    localparam int WORDS  = 1 << ADDR_W,
    localparam int BLKS_W = ADDR_W - BLK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pgm_en,
    input  logic [ADDR_W-1:0] pgm_addr,
    input  logic [15:0]       pgm_data,
    input  logic              ers_en,
    input  logic [BLKS_W-1:0] ers_blk,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [15:0]       rd_data
);

    logic [15:0] mem_q [WORDS];
    logic [15:0] mem_d [WORDS];

    always_comb begin
        for (int i = 0; i < WORDS; i++) begin
            logic [ADDR_W-1:0] wa;
            wa = ADDR_W'(i);
            mem_d[i] = mem_q[i];
            if (ers_en && (wa[ADDR_W-1:BLK_W] == ers_blk)) begin
                mem_d[i] = '1;
            end else if (pgm_en && (wa == pgm_addr)) begin
                // programming can only pull bits low
                mem_d[i] = mem_q[i] & pgm_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem_q[i] <= '1;
        end else begin
            for (int i = 0; i < WORDS; i++) mem_q[i] <= mem_d[i];
        end
    end

    assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/fcs_wbuf.sv
module fcs_wbuf #(
    parameter int ADDR_W = 8,
    parameter int DEPTH  = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [15:0]       wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [15:0]       rd_data
);

    logic [ADDR_W-1:0] a_q [DEPTH];
    logic [ADDR_W-1:0] a_d [DEPTH];
    logic [15:0]       v_q [DEPTH];
    logic [15:0]       v_d [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            a_d[i] = a_q[i];
            v_d[i] = v_q[i];
            if (wr_en && (wr_idx == IDX_W'(i))) begin
                a_d[i] = wr_addr;
                v_d[i] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                a_q[i] <= '0;
                v_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                a_q[i] <= a_d[i];
                v_q[i] <= v_d[i];
            end
        end
    end

    assign rd_addr = a_q[rd_idx];
    assign rd_data = v_q[rd_idx];

endmodule

// File: rtl/fcs_ctrl.sv
module fcs_ctrl
    import fcs_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int BLK_W     = 4,
    parameter int BUF_DEPTH = 8,
    parameter int BUSY_CYC  = 12,
    localparam int IDX_W  = $clog2(BUF_DEPTH),
    localparam int CNT_W  = $clog2(BUF_DEPTH + 1),
    localparam int TMR_W  = $clog2(BUSY_CYC + 1),
    localparam int BLKS_W = ADDR_W - BLK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       wdata,
    output logic [7:0]        status,
    output rmode_e            mode,
    output logic              busy,
    output logic              pgm_en,
    output logic [ADDR_W-1:0] pgm_addr,
    output logic [15:0]       pgm_data,
    output logic              ers_en,
    output logic [BLKS_W-1:0] ers_blk,
    output logic              buf_we,
    output logic [IDX_W-1:0]  buf_idx,
    input  logic [ADDR_W-1:0] buf_addr,
    input  logic [15:0]       buf_data
);

    localparam logic [TMR_W-1:0] TMR_INIT = TMR_W'(BUSY_CYC - 1);

    typedef struct packed {
        st_e               st;
        op_e               op;
        rmode_e            mode;
        logic [ADDR_W-1:0] tgt;
        logic [15:0]       dat;
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  idx;
        logic [TMR_W-1:0]  tmr;
        logic              err_seq;
        logic              err_pgm;
    } ctl_t;

    ctl_t q, n;
    logic [7:0] cmd;
    logic       finish;
    logic       same_blk;

    assign cmd      = wdata[7:0];
    assign same_blk = (addr[ADDR_W-1:BLK_W] == q.tgt[ADDR_W-1:BLK_W]);

    always_comb begin
        n        = q;
        pgm_en   = 1'b0;
        pgm_addr = q.tgt;
        pgm_data = q.dat;
        ers_en   = 1'b0;
        buf_we   = 1'b0;
        finish   = 1'b0;

        case (q.st)
            S_IDLE: begin
                if (we) begin
                    case (cmd)
                        CMD_WORD: begin
                            n.st   = S_WP_DATA;
                            n.mode = RM_STATUS;
                        end
                        CMD_ERASE: begin
                            n.st   = S_ER_CONF;
                            n.mode = RM_STATUS;
                        end
                        CMD_BUF: begin
                            n.st   = S_BP_CNT;
                            n.tgt  = addr;
                            n.mode = RM_STATUS;
                        end
                        CMD_CLR: begin
                            n.err_seq = 1'b0;
                            n.err_pgm = 1'b0;
                        end
                        default: n.mode = mode_after(cmd, q.mode);
                    endcase
                end
            end

            S_WP_DATA: begin
                if (we) begin
                    n.tgt = addr;
                    n.dat = wdata;
                    n.op  = OP_WORD;
                    n.tmr = TMR_INIT;
                    n.st  = S_BUSY;
                end
            end

            S_ER_CONF: begin
                if (we) begin
                    if (cmd == CMD_CONF) begin
                        n.tgt = addr;
                        n.op  = OP_ERASE;
                        n.tmr = TMR_INIT;
                        n.st  = S_BUSY;
                    end else begin
                        n.err_seq = 1'b1;
                        n.err_pgm = 1'b1;
                        n.st      = S_IDLE;
                    end
                end
            end

            S_BP_CNT: begin
                if (we) begin
                    if ((wdata == 16'd0) || (wdata > 16'(BUF_DEPTH))) begin
                        n.err_seq = 1'b1;
                        n.err_pgm = 1'b1;
                        n.st      = S_IDLE;
                    end else begin
                        n.cnt = wdata[CNT_W-1:0];
                        n.idx = '0;
                        n.st  = S_BP_LOAD;
                    end
                end
            end

            S_BP_LOAD: begin
                if (we) begin
                    if (!same_blk) begin
                        n.err_pgm = 1'b1;
                        n.st      = S_IDLE;
                    end else begin
                        buf_we = 1'b1;
                        n.idx  = q.idx + 1'b1;
                        if ((q.idx + 1'b1) == q.cnt) n.st = S_BP_CONF;
                    end
                end
            end

            S_BP_CONF: begin
                if (we) begin
                    if (cmd == CMD_CONF) begin
                        n.op  = OP_BUF;
                        n.idx = '0;
                        n.tmr = TMR_INIT;
                        n.st  = S_BUSY;
                    end else begin
                        n.err_seq = 1'b1;
                        n.err_pgm = 1'b1;
                        n.st      = S_IDLE;
                    end
                end
            end

            S_BUSY: begin
                finish = (q.tmr == '0) && ((q.op != OP_BUF) || (q.idx >= q.cnt));
                if (finish) begin
                    pgm_en = (q.op == OP_WORD);
                    ers_en = (q.op == OP_ERASE);
                    n.op   = OP_NONE;
                    n.st   = S_IDLE;
                end else begin
                    if (q.tmr != '0) n.tmr = q.tmr - 1'b1;
                    if ((q.op == OP_BUF) && (q.idx < q.cnt)) begin
                        pgm_en   = 1'b1;
                        pgm_addr = buf_addr;
                        pgm_data = buf_data;
                        n.idx    = q.idx + 1'b1;
                    end
                end
                if (we) begin
                    if (cmd == CMD_SUSP) begin
                        // completion on this edge wins over the request
                        if (!finish) n.st = S_SUSP;
                    end else if (cmd == CMD_CLR) begin
                        n.err_seq = 1'b0;
                        n.err_pgm = 1'b0;
                    end else begin
                        n.mode = mode_after(cmd, q.mode);
                    end
                end
            end

            S_SUSP: begin
                if (we) begin
                    if (cmd == CMD_CONF) begin
                        n.st   = S_BUSY;
                        n.mode = RM_STATUS;
                    end else if (cmd == CMD_CLR) begin
                        n.err_seq = 1'b0;
                        n.err_pgm = 1'b0;
                    end else begin
                        n.mode = mode_after(cmd, q.mode);
                    end
                end
            end

            default: n.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign busy    = (q.st == S_BUSY);
    assign mode    = q.mode;
    assign ers_blk = q.tgt[ADDR_W-1:BLK_W];
    assign buf_idx = q.idx[IDX_W-1:0];
    assign status  = {~busy,
                      (q.st == S_SUSP) && (q.op == OP_ERASE),
                      q.err_seq,
                      q.err_pgm,
                      1'b0,
                      (q.st == S_SUSP) && (q.op != OP_ERASE),
                      2'b00};

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import fcs_pkg::*;
#(
    parameter int          ADDR_W    = 8,
    parameter int          BLK_W     = 4,
    parameter int          BUF_DEPTH = 8,
    parameter int          BUSY_CYC  = 12,
    parameter logic [15:0] MAKER_ID  = 16'h00A5,
    parameter logic [15:0] PART_ID   = 16'h5A17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       wdata,
    output logic [15:0]       rdata
);

    localparam int IDX_W  = $clog2(BUF_DEPTH);
    localparam int BLKS_W = ADDR_W - BLK_W;

    logic [7:0]        status_w;
    rmode_e            mode_w;
    logic              busy_w;
    logic              pgm_en;
    logic [ADDR_W-1:0] pgm_addr;
    logic [15:0]       pgm_data;
    logic              ers_en;
    logic [BLKS_W-1:0] ers_blk;
    logic              buf_we;
    logic [IDX_W-1:0]  buf_idx;
    logic [ADDR_W-1:0] buf_addr;
    logic [15:0]       buf_data;
    logic [15:0]       arr_data;
    logic [15:0]       id_word;
    logic [15:0]       qry_word;

    fcs_ctrl #(
        .ADDR_W(ADDR_W), .BLK_W(BLK_W), .BUF_DEPTH(BUF_DEPTH), .BUSY_CYC(BUSY_CYC)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata),
        .status(status_w), .mode(mode_w), .busy(busy_w),
        .pgm_en(pgm_en), .pgm_addr(pgm_addr), .pgm_data(pgm_data),
        .ers_en(ers_en), .ers_blk(ers_blk),
        .buf_we(buf_we), .buf_idx(buf_idx), .buf_addr(buf_addr), .buf_data(buf_data)
    );

    fcs_wbuf #(.ADDR_W(ADDR_W), .DEPTH(BUF_DEPTH)) u_wbuf (
        .clk(clk), .rst_n(rst_n),
        .wr_en(buf_we), .wr_idx(buf_idx), .wr_addr(addr), .wr_data(wdata),
        .rd_idx(buf_idx), .rd_addr(buf_addr), .rd_data(buf_data)
    );

    fcs_array #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_array (
        .clk(clk), .rst_n(rst_n),
        .pgm_en(pgm_en), .pgm_addr(pgm_addr), .pgm_data(pgm_data),
        .ers_en(ers_en), .ers_blk(ers_blk),
        .rd_addr(addr), .rd_data(arr_data)
    );

    always_comb begin
        case (addr)
            ADDR_W'(0): id_word = MAKER_ID;
            ADDR_W'(1): id_word = PART_ID;
            default:    id_word = 16'h0000;
        endcase
        case (addr)
            ADDR_W'(16): qry_word = 16'h0051;
            ADDR_W'(17): qry_word = 16'h0052;
            ADDR_W'(18): qry_word = 16'h0059;
            default:     qry_word = 16'h0000;
        endcase
    end

    always_comb begin
        case (mode_w)
            RM_ARRAY:  rdata = busy_w ? {8'h00, status_w} : arr_data;
            RM_IDENT:  rdata = id_word;
            RM_QUERY:  rdata = qry_word;
            default:   rdata = {8'h00, status_w};
        endcase
    end

endmodule

// File: rtl/fcs_checker.sv
module fcs_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        we,
    input logic [15:0] wdata,
    input logic [7:0]  stat
);

    // R3: the engine only turns busy in response to a bus write
    a_r3_busy_from_write: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat[7]) |-> $past(we));

    // R9: program error flag drops only after a clear command
    a_r9_pgm_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat[4]) |-> $past(we && (wdata[7:0] == 8'h50)));

    // R9: sequence error flag drops only after a clear command
    a_r9_seq_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat[5]) |-> $past(we && (wdata[7:0] == 8'h50)));

    // R11: at most one kind of suspension is reported
    a_r11_one_suspend: assert property (@(posedge clk) disable iff (!rst_n)
        !(stat[6] && stat[2]));

    // R11: a suspended engine reports ready
    a_r11_ready_in_suspend: assert property (@(posedge clk) disable iff (!rst_n)
        (stat[6] || stat[2]) |-> stat[7]);

    // R11: erase suspension starts only from a suspend command
    a_r11_erase_susp_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat[6]) |-> $past(we && (wdata[7:0] == 8'hB0)));

endmodule

bind flash_cmd_seq fcs_checker u_chk (
    .clk(clk), .rst_n(rst_n), .we(we), .wdata(wdata), .stat(status_w)
);

// File: tb/sim_flash_cmd_seq.sv
module sim_flash_cmd_seq;

    localparam int CLK_P = 10;
    localparam int BC    = 12;

    logic        clk   = 1'b0;
    logic        rst_n = 1'b0;
    logic        we    = 1'b0;
    logic [7:0]  addr  = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    int n_chk  = 0;
    int n_fail = 0;

    flash_cmd_seq u0 (
        .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    always #(CLK_P / 2) clk = ~clk;

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [15:0] exp);
        @(negedge clk);
        addr = a;
        #1 chk(req, rdata, exp);
    endtask

    // counts status samples with bit 7 low, starting right after the last write
    task automatic busy_len(output int cnt);
        cnt  = 0;
        addr = 8'h00;
        #1;
        while ((rdata[7] == 1'b0) && (cnt < 200)) begin
            cnt++;
            @(negedge clk);
            #1;
        end
    endtask

    task automatic wait_ready(input string req);
        int c;
        busy_len(c);
        chk(req, 16'(c < 200), 16'd1);
    endtask

    task automatic t_reset;
        rd_chk("R1 array erased", 8'h00, 16'hFFFF);
        rd_chk("R1 array erased", 8'h37, 16'hFFFF);
        wr(8'h00, 16'h0070);
        rd_chk("R1 status after reset", 8'h00, 16'h0080);
    endtask

    task automatic t_modes;
        wr(8'h00, 16'h0090);
        rd_chk("R2 ident maker", 8'h00, 16'h00A5);
        rd_chk("R2 ident part", 8'h01, 16'h5A17);
        rd_chk("R2 ident other", 8'h05, 16'h0000);
        wr(8'h00, 16'h0098);
        rd_chk("R2 query Q", 8'h10, 16'h0051);
        rd_chk("R2 query R", 8'h11, 16'h0052);
        rd_chk("R2 query Y", 8'h12, 16'h0059);
        wr(8'h00, 16'h00FF);
        rd_chk("R2 back to array", 8'h20, 16'hFFFF);
    endtask

    task automatic t_unknown;
        wr(8'h03, 16'h0012);
        rd_chk("R13 unknown code in array mode", 8'h03, 16'hFFFF);
        wr(8'h00, 16'h0070);
        wr(8'h00, 16'h0034);
        rd_chk("R13 unknown code in status mode", 8'h03, 16'h0080);
        wr(8'h00, 16'h00FF);
    endtask

    task automatic t_word;
        int c;
        wr(8'h05, 16'h0040);
        wr(8'h05, 16'h12F0);
        busy_len(c);
        chk("R3 busy length", 16'(c), 16'(BC));
        rd_chk("R3 status after program", 8'h00, 16'h0080);
        wr(8'h00, 16'h00FF);
        rd_chk("R3 programmed word", 8'h05, 16'h12F0);
        wr(8'h05, 16'h0040);
        wr(8'h05, 16'hFF0F);
        wr(8'h00, 16'h00FF);
        rd_chk("R10 array read while busy gives status", 8'h05, 16'h0000);
        wait_ready("R3 second program finishes");
        rd_chk("R3 AND with old value", 8'h05, 16'h1200);
    endtask

    task automatic t_buf;
        wr(8'h20, 16'h00E8);
        rd_chk("R10 status mode after buffer setup", 8'h21, 16'h0080);
        wr(8'h20, 16'd3);
        wr(8'h21, 16'hAAAA);
        wr(8'h22, 16'h5555);
        wr(8'h2F, 16'h0F0F);
        wr(8'h20, 16'h00D0);
        wait_ready("R4 buffered program finishes");
        rd_chk("R4 status after buffer", 8'h00, 16'h0080);
        wr(8'h00, 16'h00FF);
        rd_chk("R4 word 0", 8'h21, 16'hAAAA);
        rd_chk("R4 word 1", 8'h22, 16'h5555);
        rd_chk("R4 word 2", 8'h2F, 16'h0F0F);
        rd_chk("R4 untouched word", 8'h23, 16'hFFFF);
    endtask

    task automatic t_abort;
        wr(8'h30, 16'h00E8);
        wr(8'h30, 16'd4);
        wr(8'h31, 16'h0000);
        wr(8'h45, 16'h0000);
        wr(8'h00, 16'h0070);
        rd_chk("R5 abort sets program error", 8'h00, 16'h0090);
        wr(8'h00, 16'h00FF);
        rd_chk("R5 loaded word discarded", 8'h31, 16'hFFFF);
        rd_chk("R5 outside word untouched", 8'h45, 16'hFFFF);
        wr(8'h00, 16'h0050);
    endtask

    task automatic t_count_err;
        wr(8'h30, 16'h00E8);
        wr(8'h30, 16'd9);
        rd_chk("R6 count above depth", 8'h00, 16'h00B0);
        wr(8'h00, 16'h0050);
        rd_chk("R9 clear restores status", 8'h00, 16'h0080);
        wr(8'h30, 16'h00E8);
        wr(8'h30, 16'd0);
        rd_chk("R6 zero count", 8'h00, 16'h00B0);
        wr(8'h00, 16'h0050);
        wr(8'h00, 16'h00FF);
        rd_chk("R6 array unchanged", 8'h30, 16'hFFFF);
    endtask

    task automatic t_erase;
        int c;
        wr(8'h20, 16'h0020);
        wr(8'h27, 16'h00D0);
        busy_len(c);
        chk("R7 erase busy length", 16'(c), 16'(BC));
        wr(8'h00, 16'h00FF);
        rd_chk("R7 erased word", 8'h21, 16'hFFFF);
        rd_chk("R7 erased word", 8'h2F, 16'hFFFF);
        rd_chk("R7 other block kept", 8'h05, 16'h1200);
    endtask

    task automatic t_conf_err;
        wr(8'h00, 16'h0020);
        wr(8'h00, 16'h0077);
        rd_chk("R8 bad erase confirm", 8'h00, 16'h00B0);
        wr(8'h00, 16'h00FF);
        rd_chk("R8 block not erased", 8'h05, 16'h1200);
        wr(8'h00, 16'h00E8);
        wr(8'h00, 16'd1);
        wr(8'h06, 16'h0000);
        wr(8'h00, 16'h0011);
        wr(8'h00, 16'h00FF);
        rd_chk("R8 buffer not programmed", 8'h06, 16'hFFFF);
    endtask

    task automatic t_sticky;
        wr(8'h0A, 16'h0040);
        wr(8'h0A, 16'h1234);
        wait_ready("R9 program finishes");
        rd_chk("R9 errors kept across operation", 8'h00, 16'h00B0);
        wr(8'h00, 16'h00FF);
        rd_chk("R9 program done", 8'h0A, 16'h1234);
        wr(8'h00, 16'h0050);
        wr(8'h00, 16'h0070);
        rd_chk("R9 clear only errors", 8'h00, 16'h0080);
    endtask

    task automatic t_suspend;
        wr(8'h31, 16'h0040);
        wr(8'h31, 16'h0000);
        wait_ready("R11 prep program");
        wr(8'h30, 16'h0020);
        wr(8'h30, 16'h00D0);
        wr(8'h00, 16'h00B0);
        rd_chk("R11 erase suspended", 8'h00, 16'h00C0);
        repeat (30) @(negedge clk);
        rd_chk("R11 stays suspended", 8'h00, 16'h00C0);
        wr(8'h00, 16'h00FF);
        rd_chk("R11 block not yet erased", 8'h31, 16'h0000);
        rd_chk("R11 array read in suspend", 8'h05, 16'h1200);
        wr(8'h00, 16'h00D0);
        rd_chk("R11 resume clears bits 7 and 6", 8'h00, 16'h0000);
        wait_ready("R11 erase finishes");
        rd_chk("R11 status after resume", 8'h00, 16'h0080);
        wr(8'h00, 16'h00FF);
        rd_chk("R11 erase completed", 8'h31, 16'hFFFF);
        wr(8'h07, 16'h0040);
        wr(8'h07, 16'h00FF);
        wr(8'h00, 16'h00B0);
        rd_chk("R11 program suspended", 8'h00, 16'h0084);
        wr(8'h00, 16'h00D0);
        rd_chk("R11 program resumed", 8'h00, 16'h0000);
        wait_ready("R11 program finishes");
        wr(8'h00, 16'h00FF);
        rd_chk("R11 program completed", 8'h07, 16'h00FF);
    endtask

    task automatic t_tie;
        wr(8'h08, 16'h0040);
        wr(8'h08, 16'h0F00);
        repeat (BC - 2) @(negedge clk);
        wr(8'h00, 16'h00B0);
        rd_chk("R12 suspend at finish ignored", 8'h00, 16'h0080);
        wr(8'h00, 16'h00FF);
        rd_chk("R12 word programmed", 8'h08, 16'h0F00);
        wr(8'h09, 16'h0040);
        wr(8'h09, 16'h00F0);
        repeat (BC - 3) @(negedge clk);
        wr(8'h00, 16'h00B0);
        rd_chk("R12 suspend one edge earlier", 8'h00, 16'h0084);
        wr(8'h00, 16'h00D0);
        wait_ready("R12 resumed program finishes");
        wr(8'h00, 16'h00FF);
        rd_chk("R12 resumed word", 8'h09, 16'h00F0);
    endtask

    initial begin
        #(CLK_P * 100000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_modes();
        t_unknown();
        t_word();
        t_buf();
        t_abort();
        t_count_err();
        t_erase();
        t_conf_err();
        t_sticky();
        t_suspend();
        t_tie();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule